// File: doc/BRIEF.md
# Two's Complement Adder/Subtractor with Twin Overflow Flags

This block adds or subtracts two signed or unsigned operands with no clock and no stored state. A single select line chooses the operation. In subtract mode each bit of the second operand passes through an XOR gate that acts as a switchable inverter, and the same select line feeds the carry input of the lowest stage. The second operand is therefore negated in two's complement before it reaches a ripple chain of full-adder cells.

The block reports overflow in two separate ways. The first flag looks only at the sign bits of the two values that enter the adder and the sign bit of the result. The second flag XORs the carry into the top stage with the carry out of it. Both flags are brought out to the ports, so surrounding logic or a checker can compare them. The carry out of the top stage is also available for unsigned use.

Top module: `addsub_ovf`

## Requirements
- R1: With `sub_sel` = 0, `{carry_out, result}` equals the (WIDTH+1)-bit unsigned sum `opa + opb`.
- R2: With `sub_sel` = 1, `{carry_out, result}` equals the (WIDTH+1)-bit value `opa + ~opb + 1`, so `carry_out` is 1 exactly when `opa >= opb` as unsigned numbers.
- R3: `ovf_sign` is 1 exactly when the sign bit of `opa` equals the sign bit of the effective second operand (`opb` MSB XOR `sub_sel`) and the MSB of `result` differs from them. This is the case exactly when the true signed result falls outside the WIDTH-bit signed range.
- R4: `ovf_sign` is 0 whenever the sign bit of `opa` differs from the sign bit of the effective second operand.
- R5: `ovf_carry` equals the carry into the MSB stage XOR `carry_out`. It is 1 exactly when the signed result is out of range.
- R6: `ovf_sign` and `ovf_carry` are equal for every input combination in both modes.
- R7: Add cases at WIDTH=8: 0x80+0x80 gives 0x00 with carry 1 and overflow 1. 0x7F+0x01 gives 0x80 with carry 0 and overflow 1. 0x7F+0x80 gives 0xFF with carry 0 and overflow 0. 0x7F+0xC0 gives 0x3F with carry 1 and overflow 0.
- R8: Subtract cases at WIDTH=8: 0x00-0x00 gives 0x00 with carry 1 and overflow 0. 0x80-0x01 gives 0x7F with carry 1 and overflow 1. 0x00-0x80 gives 0x80 with carry 0 and overflow 1. 0x05-0x07 gives 0xFE with carry 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, inverted internally when subtracting |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract; also the carry into stage 0 |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the most significant stage |
| ovf_sign | output | 1 | Overflow flag derived from the sign bits |
| ovf_carry | output | 1 | Overflow flag derived from the carries around the MSB |

## Verification
The bench builds the block with the default WIDTH of 8. At this width the operand space is small enough to sweep completely: all 65,536 operand pairs are applied in both modes. Each pair is checked against a reference computed from plain signed and unsigned integer arithmetic. The sweep therefore covers every sign combination, every carry chain length and every boundary where the two overflow methods could disagree. A table of hand-picked cases then confirms the named corner values at the extremes of the signed range.

// File: rtl/addsub_pkg.sv
// Package: shared constants for the adder/subtractor.
// Assumes: WIDTH of at least 2 so that a carry into the MSB exists.
package addsub_pkg;
    localparam int unsigned DFLT_W = 8;
    localparam int unsigned MIN_W  = 2;
endpackage

// File: rtl/fa_cell.sv
// Module: fa_cell
// One full-adder bit: sum and carry out from two data bits and a carry in.
// Assumes: purely combinational use inside a ripple chain.
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    // Propagate term, sum and majority carry.
    always_comb begin
        half = a ^ b;
        s    = half ^ ci;
        co   = (a & b) | (half & ci);
    end
endmodule

// File: rtl/ripple_chain.sv
// Module: ripple_chain
// WIDTH full-adder cells in series; exposes the carries on both sides of the MSB.
// Assumes: WIDTH >= addsub_pkg::MIN_W; the b operand is already conditioned.
module ripple_chain #(
    parameter int unsigned WIDTH = addsub_pkg::DFLT_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_msb_in,
    output logic             c_msb_out
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    // One cell per bit, carry rippling upward.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        fa_cell u_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign c_msb_in  = carry[WIDTH-1];
    assign c_msb_out = carry[WIDTH];
endmodule

// File: rtl/sign_ovf_det.sv
// Module: sign_ovf_det
// Overflow from sign bits: both inputs share a sign and the result's sign differs.
// Assumes: sb is the sign of the operand as actually fed to the adder.
module sign_ovf_det (
    input  logic sa,
    input  logic sb,
    input  logic ss,
    output logic ovf
);
    // Sum-of-products form of the sign rule.
    always_comb begin
        ovf = (sa & sb & ~ss) | (~sa & ~sb & ss);
    end
endmodule

// File: rtl/carry_ovf_det.sv
// Module: carry_ovf_det
// Overflow from carries: carry into the MSB disagrees with carry out of it.
// Assumes: both carries come from the same ripple chain.
module carry_ovf_det (
    input  logic c_in,
    input  logic c_out,
    output logic ovf
);
    // Disagreement of the two MSB carries.
    always_comb begin
        ovf = c_in ^ c_out;
    end
endmodule

// File: rtl/addsub_ovf.sv
// Module: addsub_ovf (top)
// Adds or subtracts two WIDTH-bit operands; reports carry and two overflow flags.
// Assumes: purely combinational; sub_sel both inverts opb and injects carry-in.
module addsub_ovf #(
    parameter int unsigned WIDTH = addsub_pkg::DFLT_W
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf_sign,
    output logic             ovf_carry
);
    localparam int unsigned MSB = WIDTH - 1;
    localparam int unsigned EXT = WIDTH + 2;

    logic [WIDTH-1:0] opb_eff;
    logic             c_into_msb;

    // XOR gates acting as switchable inverters on the second operand.
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign opb_eff[i] = opb[i] ^ sub_sel;
    end

    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a         (opa),
        .b         (opb_eff),
        .cin       (sub_sel),
        .sum       (result),
        .c_msb_in  (c_into_msb),
        .c_msb_out (carry_out)
    );

    sign_ovf_det u_sgn (
        .sa  (opa[MSB]),
        .sb  (opb_eff[MSB]),
        .ss  (result[MSB]),
        .ovf (ovf_sign)
    );

    carry_ovf_det u_cov (
        .c_in  (c_into_msb),
        .c_out (carry_out),
        .ovf   (ovf_carry)
    );

    // Reference values for the checks: unsigned total and true signed result.
    logic [WIDTH:0]      chk_add;
    logic [WIDTH:0]      chk_sub;
    logic signed [EXT-1:0] chk_signed;
    logic                chk_range_bad;

    // Build the reference values from the ports alone.
    always_comb begin
        chk_add    = {1'b0, opa} + {1'b0, opb};
        chk_sub    = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, 1'b1};
        chk_signed = sub_sel ? (EXT'($signed(opa)) - EXT'($signed(opb)))
                             : (EXT'($signed(opa)) + EXT'($signed(opb)));
        chk_range_bad = (chk_signed > $signed(EXT'((1 << MSB) - 1))) ||
                        (chk_signed < -$signed(EXT'(1 << MSB)));
    end

    // Checks on the chain output and on the two flag generators.
    always_comb begin
        if (!sub_sel) begin
            assert_add_value_R1: assert ({carry_out, result} == chk_add)
                else $error("R1 add result mismatch");
        end else begin
            assert_sub_value_R2: assert ({carry_out, result} == chk_sub)
                else $error("R2 subtract result mismatch");
        end
        assert_sign_flag_R3: assert (ovf_sign == chk_range_bad)
            else $error("R3 sign-bit overflow flag wrong");
        if (opa[MSB] != (opb[MSB] ^ sub_sel)) begin
            assert_no_overflow_R4: assert (!ovf_sign)
                else $error("R4 overflow with differing signs");
        end
        assert_carry_flag_R5: assert (ovf_carry == chk_range_bad)
            else $error("R5 carry-based overflow flag wrong");
        assert_flags_agree_R6: assert (ovf_sign == ovf_carry)
            else $error("R6 overflow flags disagree");
    end
endmodule

// File: tb/sim_addsub_ovf.sv
// Bench for addsub_ovf: vector table, exhaustive sweep, directed idle check.
module sim_addsub_ovf;
    localparam int W = 8;
    localparam int NV = 10;

    logic clk = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic sub_sel = 1'b0;
    logic [W-1:0] result;
    logic carry_out, ovf_sign, ovf_carry;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addsub_ovf #(.WIDTH(W)) u0 (
        .opa(opa), .opb(opb), .sub_sel(sub_sel),
        .result(result), .carry_out(carry_out),
        .ovf_sign(ovf_sign), .ovf_carry(ovf_carry)
    );

    // Row: {a, b, sub, result, carry, overflow}. Rows 0-3 R7, rows 4-7 R8.
    typedef logic [26:0] vec_t;
    localparam vec_t VECS [NV] = '{
        {8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1},
        {8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1},
        {8'h7F, 8'h80, 1'b0, 8'hFF, 1'b0, 1'b0},
        {8'h7F, 8'hC0, 1'b0, 8'h3F, 1'b1, 1'b0},
        {8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0},
        {8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b1},
        {8'h00, 8'h80, 1'b1, 8'h80, 1'b0, 1'b1},
        {8'h05, 8'h07, 1'b1, 8'hFE, 1'b0, 1'b0},
        {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0},
        {8'h0F, 8'h01, 1'b0, 8'h10, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h sub=%0b)",
                     tag, act, exp, opa, opb, sub_sel);
        end
    endtask

    task automatic apply(input int a, input int b, input bit s);
        @(negedge clk);
        opa = W'(a);
        opb = W'(b);
        sub_sel = s;
        #1;
    endtask

    task automatic check_model(input int a, input int b, input bit s);
        int tot, sa, sb, r, v;
        tot = a + (s ? ((~b) & 8'hFF) : b) + (s ? 1 : 0);
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        r = s ? sa - sb : sa + sb;
        v = (r > 127 || r < -128) ? 1 : 0;
        chk(s ? "R2" : "R1", {23'd0, carry_out, result}, tot);
        chk("R3", int'(ovf_sign), v);
        if (a[7] != (b[7] ^ s)) chk("R4", int'(ovf_sign), 0);
        chk("R5", int'(ovf_carry), v);
        chk("R6", int'(ovf_carry), int'(ovf_sign));
    endtask

    initial begin
        // Idle state: all-zero inputs give all-zero outputs (R1).
        apply(0, 0, 1'b0);
        chk("R1", {23'd0, carry_out, ovf_sign, ovf_carry, result}, 0);

        // Vector table walk.
        for (int k = 0; k < NV; k++) begin
            apply(int'(VECS[k][26:19]), int'(VECS[k][18:11]), VECS[k][10]);
            chk(k < 4 ? "R7" : "R8", int'(result), int'(VECS[k][9:2]));
            chk(k < 4 ? "R7" : "R8", int'(carry_out), int'(VECS[k][1]));
            chk(k < 4 ? "R7" : "R8", int'(ovf_sign), int'(VECS[k][0]));
            chk(k < 4 ? "R7" : "R8", int'(ovf_carry), int'(VECS[k][0]));
        end

        // Exhaustive sweep, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(a, b, m[0]);
                    check_model(a, b, m[0]);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule